// File: doc/BRIEF.md
# I/O Control Register Pair with Super-I/O Port Decode

This block holds two 32-bit read/write control words that sit at byte offsets 0 and 4 of an I/O window. A simple synchronous register port carries writes, with one enable per byte. Reads return the addressed word combinationally. The fields of the two words drive enables for the neighbouring super-I/O, USB, video and IDSEL logic.

Beyond storing fields, the block does three more jobs:
- It decodes incoming I/O cycles against the configuration port pair that the first word selects.
- It gates USB-generated SMI requests and records them in a sticky status flag.
- It hides one bit of the second word on readback until that word has been written once.

Top module: `ioctl_regs`

## Requirements
- R1: After reset, offset 0 reads 32'h010C0007. Offset 4 reads 32'h00000000: its stored value is 32'h00000002, but bit 1 is hidden. At the same time `video_acc_en`=1, `idsel_alt`=0, `usb_port_en`=1, `sio_isa_drive_en`=1, `sio_mode`=2'b00 and `smi_status`=0.
- R2: A write with `reg_wr`=1 changes only the bytes whose `reg_be` bit is set (bit i covers data bits 8i+7:8i). It takes effect at the next rising clock edge. `reg_rdata` follows `reg_addr` combinationally, and any address other than 0 and 4 reads zero.
- R3: At offset 0 only bits 27, 26:25, 24, 20, 19 and 18 are writable. All other bits ignore writes and always read their reset constant: bits 2:0 read 1 and the rest read 0.
- R4: The fields of offset 0 drive these outputs continuously:
  - `sio_ir_en` = bit 27
  - `sio_mode` = bits 26:25
  - `sio_isa_drive_en` = bit 24
  - `usb_port_en` = bit 18
- R5: `sio_cfg_hit` is 1 exactly when `io_valid` is 1 and one of these holds:
  - `sio_mode` is 2'b10 and `io_addr` is 16'h002E or 16'h002F;
  - `sio_mode` is 2'b11 and `io_addr` is 16'h015C or 16'h015D.
  Mode 2'b00 (super-I/O off) and mode 2'b01 (configuration access off) never hit.
- R6: `smi_out` equals `usb_smi_req` AND offset 0 bit 19. It is combinational.
- R7: `smi_status` becomes 1 at the edge after a cycle in which `usb_smi_req`, bit 19 and bit 20 are all 1. It stays set until a cycle with `smi_status_clr`=1. A set in that same cycle wins over the clear.
- R8: Offset 4 bits 31:2 and bit 0 store whatever is written and read it back. Bit 0 drives `idsel_alt`: 0 selects the AD28 (chipset) / AD29 (USB) line pair, and 1 selects the AD26 / AD27 pair.
- R9: Offset 4 bit 1 drives `video_acc_en` from reset onward. On readback it returns 0 until offset 4 has seen a write with at least one byte enable set. After that it returns its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for the write |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| io_valid | input | 1 | An I/O cycle is present on `io_addr` |
| io_addr | input | 16 | I/O cycle address |
| sio_cfg_hit | output | 1 | I/O cycle matches the selected configuration port |
| usb_smi_req | input | 1 | SMI request from USB |
| smi_status_clr | input | 1 | Clears the sticky SMI status |
| smi_out | output | 1 | Gated SMI request |
| smi_status | output | 1 | Sticky USB SMI status |
| sio_ir_en | output | 1 | Super-I/O infrared enable |
| sio_mode | output | 2 | Super-I/O configuration mode |
| sio_isa_drive_en | output | 1 | Super-I/O may drive the internal ISA bus |
| usb_port_en | output | 1 | USB ports enable |
| video_acc_en | output | 1 | Video processor access enable |
| idsel_alt | output | 1 | Alternate IDSEL line pair select |

## Verification
The results fall due at two different times:
- **Same cycle.** `reg_rdata`, `sio_cfg_hit` and `smi_out` are combinational in the current inputs and current register state.
- **After the next rising edge.** Register contents, the field outputs, the readback-reveal flag and `smi_status` change only at the rising edge that follows the cycle carrying the stimulus.

The bench drives every input at the falling edge and samples one time step later. It compares against a model that still holds the pre-edge state. The model takes the cycle's write, set and clear only after the rising edge, so a stimulus is seen in the combinational checks of its own cycle and in the state checks of the following one.

// File: rtl/ioctl_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the I/O control register pair.
// Assumes 32-bit control words; field positions are fixed by the neighbours that decode them.
package ioctl_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        SIO_OFF       = 2'b00,
        SIO_CFG_OFF   = 2'b01,
        SIO_PORT_LOW  = 2'b10,
        SIO_PORT_HIGH = 2'b11
    } sio_mode_e;

    localparam logic [DATA_W-1:0] CR1_RESET = 32'h010C_0007;
    localparam logic [DATA_W-1:0] CR1_WMASK = 32'h0F1C_0000;
    localparam logic [DATA_W-1:0] CR2_RESET = 32'h0000_0002;

    localparam int B_IR      = 27;
    localparam int B_MODE_HI = 26;
    localparam int B_MODE_LO = 25;
    localparam int B_ISA     = 24;
    localparam int B_SMI_LOG = 20;
    localparam int B_SMI_EN  = 19;
    localparam int B_USB     = 18;
    localparam int B_VIDEO   = 1;
    localparam int B_IDSEL   = 0;
endpackage

// File: rtl/ioctl_regfile.sv
`timescale 1ns/1ps
// Holds both control words, applies byte-enabled writes and muxes readback.
// Assumes reg_addr is a byte offset; only offsets 0 and 4 are mapped.
// Bit 1 of the second word reads 0 until that word sees its first real write.
module ioctl_regfile
    import ioctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] rdata,
    output logic              f_ir,
    output logic [1:0]        f_mode,
    output logic              f_isa,
    output logic              f_smi_log,
    output logic              f_smi_en,
    output logic              f_usb,
    output logic              f_video,
    output logic              f_idsel
);
    localparam logic [ADDR_W-1:0] OFS_CR1 = '0;
    localparam logic [ADDR_W-1:0] OFS_CR2 = ADDR_W'(4);

    logic [DATA_W-1:0] cr1_q, cr2_q, bmask;
    logic [DATA_W-1:0] cr1_merge, cr2_merge;
    logic              cr2_seen;
    logic              wr_cr1, wr_cr2;

    // Expand byte enables into a bit mask.
    for (genvar b = 0; b < BE_W; b++) begin : g_bmask
        assign bmask[b*8 +: 8] = {8{be[b]}};
    end

    assign wr_cr1    = wr_en && (addr == OFS_CR1);
    assign wr_cr2    = wr_en && (addr == OFS_CR2);
    assign cr1_merge = (cr1_q & ~bmask) | (wdata & bmask);
    assign cr2_merge = (cr2_q & ~bmask) | (wdata & bmask);

    // First word: keep writable fields, pin reserved bits to reset constant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cr1_q <= CR1_RESET;
        else if (wr_cr1)
            cr1_q <= (cr1_merge & CR1_WMASK) | (CR1_RESET & ~CR1_WMASK);
    end

    // Second word: every bit stores the written value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cr2_q <= CR2_RESET;
        else if (wr_cr2)
            cr2_q <= cr2_merge;
    end

    // Remember that the second word has been written at least once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cr2_seen <= 1'b0;
        else if (wr_cr2 && (|be))
            cr2_seen <= 1'b1;
    end

    // Combinational readback of the addressed word.
    always_comb begin
        case (addr)
            OFS_CR1: rdata = cr1_q;
            OFS_CR2: rdata = {cr2_q[DATA_W-1:2], cr2_q[B_VIDEO] & cr2_seen, cr2_q[B_IDSEL]};
            default: rdata = '0;
        endcase
    end

    assign f_ir      = cr1_q[B_IR];
    assign f_mode    = cr1_q[B_MODE_HI:B_MODE_LO];
    assign f_isa     = cr1_q[B_ISA];
    assign f_smi_log = cr1_q[B_SMI_LOG];
    assign f_smi_en  = cr1_q[B_SMI_EN];
    assign f_usb     = cr1_q[B_USB];
    assign f_video   = cr2_q[B_VIDEO];
    assign f_idsel   = cr2_q[B_IDSEL];

    // R9: once revealed, the stored bit stays visible.
    a_r9_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cr2_seen |=> cr2_seen);
    // R8: second word holds when it is not written.
    a_r8_cr2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cr2 |=> $stable(cr2_q));
    // R3: first word holds when it is not written.
    a_r3_cr1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cr1 |=> $stable(cr1_q));
endmodule

// File: rtl/sio_port_decode.sv
`timescale 1ns/1ps
// Matches I/O cycles against the configuration port pair picked by the mode field.
// Assumes each pair is NUM_PORTS consecutive addresses starting at a base.
module sio_port_decode
    import ioctl_pkg::*;
#(
    parameter int                IO_ADDR_W = 16,
    parameter int                NUM_PORTS = 2,
    parameter logic [IO_ADDR_W-1:0] BASE_LOW  = 16'h002E,
    parameter logic [IO_ADDR_W-1:0] BASE_HIGH = 16'h015C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_valid,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [1:0]           mode,
    output logic                 hit
);
    logic [NUM_PORTS-1:0] m_low, m_high;

    // One comparator per port of each candidate pair.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign m_low[p]  = (io_addr == BASE_LOW  + IO_ADDR_W'(p));
        assign m_high[p] = (io_addr == BASE_HIGH + IO_ADDR_W'(p));
    end

    // Select the pair named by the mode; other modes never match.
    always_comb begin
        case (sio_mode_e'(mode))
            SIO_PORT_LOW:  hit = io_valid && (|m_low);
            SIO_PORT_HIGH: hit = io_valid && (|m_high);
            default:       hit = 1'b0;
        endcase
    end

    // R5: a hit needs a live cycle and a port-enabled mode.
    a_r5_hit_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (io_valid && mode[1]));
endmodule

// File: rtl/usb_smi_route.sv
`timescale 1ns/1ps
// Gates USB SMI requests and keeps a sticky status flag for the logged ones.
// Assumes a set and a clear in the same cycle leave the flag set.
module usb_smi_route (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic gate_en,
    input  logic log_en,
    input  logic clr,
    output logic smi_out,
    output logic status
);
    logic set_now;

    assign smi_out = req && gate_en;
    assign set_now = smi_out && log_en;

    // Sticky status: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 1'b0;
        else if (set_now)
            status <= 1'b1;
        else if (clr)
            status <= 1'b0;
    end

    // R7: a logged request sets the flag at the next edge.
    a_r7_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gate_en && log_en) |=> status);
    // R7: without a clear the flag stays set.
    a_r7_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);
endmodule

// File: rtl/ioctl_regs.sv
`timescale 1ns/1ps
// Top of the I/O control register pair: register file, super-I/O port decode
// and USB SMI routing. Assumes a single synchronous register port with no wait states.
module ioctl_regs
    import ioctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int IO_ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [BE_W-1:0]      reg_be,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 io_valid,
    input  logic [IO_ADDR_W-1:0] io_addr,
    output logic                 sio_cfg_hit,
    input  logic                 usb_smi_req,
    input  logic                 smi_status_clr,
    output logic                 smi_out,
    output logic                 smi_status,
    output logic                 sio_ir_en,
    output logic [1:0]           sio_mode,
    output logic                 sio_isa_drive_en,
    output logic                 usb_port_en,
    output logic                 video_acc_en,
    output logic                 idsel_alt
);
    logic f_smi_log, f_smi_en;

    ioctl_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .be(reg_be), .rdata(reg_rdata),
        .f_ir(sio_ir_en), .f_mode(sio_mode), .f_isa(sio_isa_drive_en),
        .f_smi_log(f_smi_log), .f_smi_en(f_smi_en), .f_usb(usb_port_en),
        .f_video(video_acc_en), .f_idsel(idsel_alt)
    );

    sio_port_decode #(.IO_ADDR_W(IO_ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
        .mode(sio_mode), .hit(sio_cfg_hit)
    );

    usb_smi_route u_smi (
        .clk(clk), .rst_n(rst_n), .req(usb_smi_req), .gate_en(f_smi_en),
        .log_en(f_smi_log), .clr(smi_status_clr), .smi_out(smi_out),
        .status(smi_status)
    );

    // R6: no SMI leaves the block without a request.
    a_r6_smi_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        smi_out |-> usb_smi_req);
    // R7: the flag only rises after a gated request.
    a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_status) |-> $past(smi_out));
endmodule

// File: tb/tb_ioctl_regs.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random traffic.
module tb_ioctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_rdata;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic        sio_cfg_hit;
    logic        usb_smi_req = 1'b0;
    logic        smi_status_clr = 1'b0;
    logic        smi_out, smi_status, sio_ir_en, sio_isa_drive_en;
    logic [1:0]  sio_mode;
    logic        usb_port_en, video_acc_en, idsel_alt;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] m1, m2;
    logic        mseen, mstat;

    always #5 clk = ~clk;

    ioctl_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .io_valid(io_valid), .io_addr(io_addr), .sio_cfg_hit(sio_cfg_hit),
        .usb_smi_req(usb_smi_req), .smi_status_clr(smi_status_clr),
        .smi_out(smi_out), .smi_status(smi_status), .sio_ir_en(sio_ir_en),
        .sio_mode(sio_mode), .sio_isa_drive_en(sio_isa_drive_en),
        .usb_port_en(usb_port_en), .video_acc_en(video_acc_en),
        .idsel_alt(idsel_alt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bytemask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'd0) return m1;
        if (a == 8'd4) return mseen ? m2 : (m2 & ~32'h2);
        return 32'h0;
    endfunction

    function automatic logic exp_hit(input logic v, input logic [15:0] ia);
        if (!v) return 1'b0;
        if (m1[26:25] == 2'b10) return (ia == 16'h002E) || (ia == 16'h002F);
        if (m1[26:25] == 2'b11) return (ia == 16'h015C) || (ia == 16'h015D);
        return 1'b0;
    endfunction

    // One cycle: drive at falling edge, check, then advance model past rising edge.
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input logic iov, input logic [15:0] ioa,
                       input logic req, input logic clr);
        logic [31:0] bm;
        string rtag;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; reg_be = be;
        io_valid = iov; io_addr = ioa; usb_smi_req = req; smi_status_clr = clr;
        #1;
        rtag = (a == 8'd0) ? "R3 read offset 0" : (a == 8'd4) ? "R9 read offset 4" : "R2 unmapped read";
        chk(rtag, reg_rdata, exp_read(a));
        chk("R4 ir", {31'b0, sio_ir_en}, {31'b0, m1[27]});
        chk("R4 mode", {30'b0, sio_mode}, {30'b0, m1[26:25]});
        chk("R4 isa", {31'b0, sio_isa_drive_en}, {31'b0, m1[24]});
        chk("R4 usb", {31'b0, usb_port_en}, {31'b0, m1[18]});
        chk("R5 hit", {31'b0, sio_cfg_hit}, {31'b0, exp_hit(iov, ioa)});
        chk("R6 smi", {31'b0, smi_out}, {31'b0, req & m1[19]});
        chk("R7 status", {31'b0, smi_status}, {31'b0, mstat});
        chk("R8 idsel", {31'b0, idsel_alt}, {31'b0, m2[0]});
        chk("R9 video", {31'b0, video_acc_en}, {31'b0, m2[1]});
        @(posedge clk);
        bm = bytemask(be);
        if (req && m1[19] && m1[20]) mstat = 1'b1;
        else if (clr) mstat = 1'b0;
        if (wr && a == 8'd0)
            m1 = ((((m1 & ~bm) | (wd & bm)) & 32'h0F1C_0000) | (32'h010C_0007 & ~32'h0F1C_0000));
        if (wr && a == 8'd4) begin
            m2 = (m2 & ~bm) | (wd & bm);
            if (be != 4'h0) mseen = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0]  ra;
        logic [15:0] ia;
        logic [2:0]  pick;
        void'($urandom(32'd2024));
        m1 = 32'h010C_0007; m2 = 32'h0000_0002; mseen = 1'b0; mstat = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state, checked against literal values.
        reg_addr = 8'd0; #1;
        chk("R1 offset 0 reset", reg_rdata, 32'h010C_0007);
        reg_addr = 8'd4; #1;
        chk("R1 offset 4 reset", reg_rdata, 32'h0000_0000);
        chk("R1 outputs", {24'b0, video_acc_en, idsel_alt, usb_port_en, sio_isa_drive_en,
                           sio_mode, smi_status, sio_ir_en},
                          {24'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0});

        // R9: a write with no byte enables does not reveal bit 1.
        cyc(1, 8'd4, 32'hFFFF_FFFF, 4'h0, 0, 0, 0, 0);
        cyc(0, 8'd4, 0, 0, 0, 0, 0, 0);
        chk("R9 still hidden", reg_rdata, 32'h0);
        // R2/R8: one byte written reveals bit 1 and updates only byte 1.
        cyc(1, 8'd4, 32'hA5A5_A5A5, 4'h2, 0, 0, 0, 0);
        cyc(0, 8'd4, 0, 0, 0, 0, 0, 0);
        chk("R2 byte 1 only", reg_rdata, 32'h0000_A502);
        // R3: reserved bits of offset 0 ignore writes.
        cyc(1, 8'd0, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0);
        cyc(0, 8'd0, 0, 0, 0, 0, 0, 0);
        chk("R3 masked write", reg_rdata, 32'h0F1C_0007);
        // R5: each mode against each port, plus the neighbours.
        for (int md = 0; md < 4; md++) begin
            cyc(1, 8'd0, {5'b0, md[1:0], 25'b0} | 32'h001C_0000, 4'h8, 0, 0, 0, 0);
            cyc(0, 8'd1, 0, 0, 1, 16'h002E, 0, 0);
            cyc(0, 8'd1, 0, 0, 1, 16'h002F, 0, 0);
            cyc(0, 8'd1, 0, 0, 1, 16'h0030, 0, 0);
            cyc(0, 8'd1, 0, 0, 1, 16'h015C, 0, 0);
            cyc(0, 8'd1, 0, 0, 1, 16'h015D, 0, 0);
            cyc(0, 8'd1, 0, 0, 0, 16'h015C, 0, 0);
        end
        // R7: set and clear together leaves the flag set, then a clear alone.
        cyc(0, 8'd8, 0, 0, 0, 0, 1, 1);
        cyc(0, 8'd8, 0, 0, 0, 0, 0, 0);
        chk("R7 set beats clear", {31'b0, smi_status}, 32'h1);
        cyc(0, 8'd8, 0, 0, 0, 0, 0, 1);
        cyc(0, 8'd8, 0, 0, 0, 0, 0, 0);
        chk("R7 cleared", {31'b0, smi_status}, 32'h0);
        // R6/R7: gate on but logging off raises SMI without status.
        cyc(1, 8'd0, 32'h0008_0000, 4'h4, 0, 0, 0, 0);
        cyc(0, 8'd0, 0, 0, 0, 0, 1, 0);
        cyc(0, 8'd0, 0, 0, 0, 0, 0, 0);
        chk("R7 no log without bit 20", {31'b0, smi_status}, 32'h0);

        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            pick = 3'($urandom_range(0, 7));
            case (pick)
                3'd0, 3'd1, 3'd2: ra = 8'd0;
                3'd3, 3'd4, 3'd5: ra = 8'd4;
                3'd6: ra = 8'd8;
                default: ra = 8'($urandom_range(1, 3));
            endcase
            pick = 3'($urandom_range(0, 7));
            case (pick)
                3'd0: ia = 16'h002E;
                3'd1: ia = 16'h002F;
                3'd2: ia = 16'h015C;
                3'd3: ia = 16'h015D;
                3'd4: ia = 16'h002D;
                3'd5: ia = 16'h015E;
                default: ia = 16'($urandom);
            endcase
            cyc(1'($urandom_range(0, 1)), ra, $urandom, 4'($urandom),
                1'($urandom_range(0, 1)), ia, 1'($urandom_range(0, 1)),
                ($urandom_range(0, 7) == 0));
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule